// File: doc/BRIEF.md
# Security-ID Fuse Readout Controller

This block puts a one-time-programmable security-ID fuse array behind a plain 32-bit register bus made of address, write enable, write data and read data. Software can read a fuse word in either of two ways. The first is the value window, where each word of the array is mapped at its own bus address and returns its value combinationally. The second is the command path. Software writes a word index, an unlock code and a start bit into the control register. It polls until the start bit clears, fetches the word from the result register, and then writes zero to the control register to close the operation.

The fuse array is modelled as a synchronous ROM whose read port has a configurable latency. The window port gives the latched sense values. The command port runs a fresh read through a pipeline that is `RD_LAT` stages deep. The array is filled with a fixed pattern that the testbench can compute on its own. Bus addresses are byte addresses, all accesses are 32-bit, and address bits 1:0 are ignored.

Top module: `otp_key_ctrl`

## Requirements
- R1: After reset, the control register (byte address 0x040) and the result register (byte address 0x060) both read zero.
- R2: A write to 0x040 is accepted when all of these hold: the block is idle, bit 1 of the write data is 1, and bits 15:8 equal 0xAC. An accepted write latches bits 24:16 as the word index. The control register then reads back as index in bits 24:16, 0xAC in bits 15:8, start in bit 1, and zero elsewhere.
- R3: A write to 0x040 with bit 1 set and any unlock code other than 0xAC is ignored. The start bit stays clear and the result register is unchanged.
- R4: After a write is accepted on a clock edge, the start bit reads 1 for exactly `RD_LAT`+1 cycles and then reads 0.
- R5: When the start bit clears, the result register holds the array word at the latched index, or zero when the index is 64 or more. The result keeps that value until the next command completes.
- R6: Any write to 0x040 while the start bit is set is ignored. The latched index, the code and the completion time are not affected.
- R7: A write to 0x040 with bit 1 clear while idle sets the whole control register to zero and leaves the result register unchanged.
- R8: A read of byte address 0x200 + 4·i, for i from 0 to 63, returns array word i. This is the same value the command path returns for index i.
- R9: Reads of any other address return zero. Writes to 0x060 and to the value window have no effect.
- R10: Array word i is (i × 0x9E3779B1) XOR 0x5EC01D00, keeping the low 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
Nearly every wrong internal state reaches `bus_rdata` within one cycle, because the control and result registers can be read back at any time. A lost or spurious start bit shows up on the next poll of 0x040. A mis-latched index or a clobbered result shows up on the first read of 0x060 after completion, and the same word is cross-checked against the window. A read pipeline with the wrong depth shifts the cycle in which the start bit falls, so the bench compares every cycle against its own model of the start bit and catches a shift of even one cycle.

// File: rtl/otp_key_pkg.sv
package otp_key_pkg;

  // Control word field layout (software visible, decoded by the sequencer).
  localparam int unsigned IDX_LSB   = 16;
  localparam int unsigned IDX_W     = 9;
  localparam int unsigned CODE_LSB  = 8;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned START_POS = 1;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] code;
    logic              start;
  } ctrl_t;

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[IDX_LSB +: IDX_W]   = c.idx;
    w[CODE_LSB +: CODE_W] = c.code;
    w[START_POS]          = c.start;
    return w;
  endfunction

  // Fuse array content: golden-ratio hash of the word index mixed with a seed.
  function automatic logic [31:0] fuse_pattern(input logic [IDX_W-1:0] i,
                                               input logic [31:0] seed);
    logic [31:0] prod;
    prod = 32'(i) * 32'h9E37_79B1;
    return prod ^ seed;
  endfunction

endpackage

// File: rtl/otp_fuse_rom.sv
module otp_fuse_rom
  import otp_key_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned LAT    = 8,
  parameter logic [31:0] SEED   = 32'h5EC0_1D00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] win_idx,
  output logic [31:0]      win_data,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [31:0]      rd_data
);

  function automatic logic [31:0] word_at(input logic [IDX_W-1:0] i);
    if (32'(i) < DEPTH) return fuse_pattern(i, SEED);
    return '0;
  endfunction

  // Latched sense values for the direct window.
  assign win_data = word_at(win_idx);

  // Sense pipeline for the command port.
  logic [LAT-1:0] vld_in;
  logic [LAT-1:0] vld_q;
  logic [31:0]    dat_in [LAT];
  logic [31:0]    dat_q  [LAT];

  genvar s;
  generate
    for (s = 0; s < LAT; s++) begin : g_stage
      if (s == 0) begin : g_head
        assign vld_in[s] = rd_req;
        assign dat_in[s] = word_at(rd_idx);
      end else begin : g_body
        assign vld_in[s] = vld_q[s-1];
        assign dat_in[s] = dat_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q[s] <= 1'b0;
        else        vld_q[s] <= vld_in[s];
      end

      always_ff @(posedge clk) begin
        if (vld_in[s]) dat_q[s] <= dat_in[s];
      end
    end
  endgenerate

  assign rd_valid = vld_q[LAT-1];
  assign rd_data  = dat_q[LAT-1];

endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_key_pkg::*;
#(
  parameter logic [CODE_W-1:0] UNLOCK = 8'hAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [31:0]      wdata,
  input  logic             rd_valid,
  input  logic [31:0]      rd_data,
  output ctrl_t            ctrl,
  output logic [31:0]      result,
  output logic             rd_req,
  output logic [IDX_W-1:0] rd_idx
);

  ctrl_t       ctrl_q, ctrl_d;
  logic        ctrl_en;
  logic [31:0] res_q, res_d;
  logic        res_en;
  logic        req_q, req_d;
  logic        accept, clear, done;

  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:IDX_LSB+IDX_W], wdata[CODE_LSB-1:START_POS+1], wdata[0]};

  always_comb begin
    done    = ctrl_q.start && rd_valid;
    accept  = ctrl_we && !ctrl_q.start && wdata[START_POS]
              && (wdata[CODE_LSB +: CODE_W] == UNLOCK);
    clear   = ctrl_we && !ctrl_q.start && !wdata[START_POS];

    ctrl_d  = ctrl_q;
    ctrl_en = 1'b0;
    res_d   = res_q;
    res_en  = 1'b0;
    req_d   = 1'b0;

    if (done) begin
      ctrl_d.start = 1'b0;
      ctrl_en      = 1'b1;
      res_d        = rd_data;
      res_en       = 1'b1;
    end else if (accept) begin
      ctrl_d.idx   = wdata[IDX_LSB +: IDX_W];
      ctrl_d.code  = UNLOCK;
      ctrl_d.start = 1'b1;
      ctrl_en      = 1'b1;
      req_d        = 1'b1;
    end else if (clear) begin
      ctrl_d  = '0;
      ctrl_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      res_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (res_en)  res_q  <= res_d;
      req_q <= req_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign result = res_q;
  assign rd_req = req_q;
  assign rd_idx = ctrl_q.idx;

endmodule

// File: rtl/otp_bus_regs.sv
module otp_bus_regs
  import otp_key_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]    CTRL_ADDR = 12'h040,
  parameter logic [ADDR_W-1:0]    RES_ADDR  = 12'h060,
  parameter logic [ADDR_W-1:0]    WIN_BASE  = 12'h200,
  parameter int unsigned          WIN_BYTES = 256
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  ctrl_t             ctrl,
  input  logic [31:0]       result,
  input  logic [31:0]       win_data,
  output logic              ctrl_we,
  output logic [IDX_W-1:0]  win_idx,
  output logic [31:0]       rdata
);

  localparam int unsigned WA = ADDR_W - 2;

  logic [WA-1:0]     waddr;
  logic [ADDR_W-1:0] woff;
  logic              hit_ctrl, hit_res, hit_win;

  assign waddr = addr[ADDR_W-1:2];
  assign woff  = addr - WIN_BASE;

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], woff[ADDR_W-1:IDX_W+2], woff[1:0]};

  always_comb begin
    hit_ctrl = (waddr == CTRL_ADDR[ADDR_W-1:2]);
    hit_res  = (waddr == RES_ADDR[ADDR_W-1:2]);
    hit_win  = (32'(waddr) >= 32'(WIN_BASE[ADDR_W-1:2]))
               && (32'(waddr) < 32'(WIN_BASE[ADDR_W-1:2]) + WIN_BYTES / 4);
    win_idx  = woff[IDX_W+1:2];
    ctrl_we  = we && hit_ctrl;

    if (hit_ctrl)     rdata = ctrl_to_word(ctrl);
    else if (hit_res) rdata = result;
    else if (hit_win) rdata = win_data;
    else              rdata = '0;
  end

endmodule

// File: rtl/otp_key_ctrl.sv
module otp_key_ctrl
  import otp_key_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 12,
  parameter logic [11:0]       CTRL_ADDR = 12'h040,
  parameter logic [11:0]       RES_ADDR  = 12'h060,
  parameter logic [11:0]       WIN_BASE  = 12'h200,
  parameter int unsigned       WIN_BYTES = 256,
  parameter int unsigned       RD_LAT    = 8,
  parameter logic [7:0]        UNLOCK    = 8'hAC,
  parameter logic [31:0]       SEED      = 32'h5EC0_1D00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int unsigned DEPTH = WIN_BYTES / 4;

  // Reset: asserted asynchronously, released on the second edge.
  logic [1:0] rs_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  ctrl_t            seq_ctrl;
  logic [31:0]      result;
  logic             rd_req, rd_valid, ctrl_we;
  logic [IDX_W-1:0] rd_idx, win_idx;
  logic [31:0]      rd_data, win_data;

  otp_bus_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR[ADDR_W-1:0]), .RES_ADDR(RES_ADDR[ADDR_W-1:0]),
    .WIN_BASE(WIN_BASE[ADDR_W-1:0]), .WIN_BYTES(WIN_BYTES)
  ) i_regs (
    .addr(bus_addr), .we(bus_we), .ctrl(seq_ctrl), .result(result),
    .win_data(win_data), .ctrl_we(ctrl_we), .win_idx(win_idx), .rdata(bus_rdata)
  );

  otp_cmd_seq #(.UNLOCK(UNLOCK)) i_seq (
    .clk(clk), .rst_n(rst_sn), .ctrl_we(ctrl_we), .wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ctrl(seq_ctrl), .result(result),
    .rd_req(rd_req), .rd_idx(rd_idx)
  );

  otp_fuse_rom #(.DEPTH(DEPTH), .LAT(RD_LAT), .SEED(SEED)) i_rom (
    .clk(clk), .rst_n(rst_sn), .win_idx(win_idx), .win_data(win_data),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data)
  );

endmodule

// File: rtl/otp_key_ctrl_chk.sv
module otp_key_ctrl_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [11:0] CTRL_ADDR = 12'h040,
  parameter logic [11:0] RES_ADDR  = 12'h060,
  parameter logic [11:0] WIN_BASE  = 12'h200,
  parameter int unsigned WIN_BYTES = 256,
  parameter logic [7:0]  UNLOCK    = 8'hAC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [8:0]        idx,
  input logic [7:0]        code,
  input logic [31:0]       result,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata
);

  logic mapped;
  always_comb begin
    mapped = (bus_addr[ADDR_W-1:2] == CTRL_ADDR[ADDR_W-1:2])
          || (bus_addr[ADDR_W-1:2] == RES_ADDR[ADDR_W-1:2])
          || ((32'(bus_addr) >= 32'(WIN_BASE))
              && (32'(bus_addr) < 32'(WIN_BASE) + WIN_BYTES));
  end

  // R2
  req_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (start && code == UNLOCK));

  // R4
  start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start) |-> $past(rd_valid));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_valid) |-> $stable(result));

  // R6
  busy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $past(start)) |-> ($stable(idx) && $stable(code)));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == 32'h0));

endmodule

bind otp_key_ctrl otp_key_ctrl_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RES_ADDR(RES_ADDR),
  .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES), .UNLOCK(UNLOCK)
) i_chk (
  .clk(clk), .rst_n(rst_sn), .start(seq_ctrl.start), .idx(seq_ctrl.idx),
  .code(seq_ctrl.code), .result(result), .rd_req(rd_req), .rd_valid(rd_valid),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/test_otp_key_ctrl.sv
`timescale 1ns/1ps
module test_otp_key_ctrl;

  localparam int LAT = 8;
  localparam logic [11:0] A_CTRL = 12'h040;
  localparam logic [11:0] A_RES  = 12'h060;
  localparam logic [11:0] A_WIN  = 12'h200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;

  always #10 clk = ~clk;

  otp_key_ctrl i_otp_key_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // R10 content, computed from the requirement.
  function automatic logic [31:0] fw(input int i);
    logic [31:0] p;
    if (i >= 64) return 32'h0;
    p = i * 32'h9E3779B1;
    return p ^ 32'h5EC01D00;
  endfunction

  function automatic logic [31:0] cmd(input int i, input logic [7:0] c, input bit go);
    return {7'b0, 9'(i), c, 6'b0, go, 1'b0};
  endfunction

  // Behavioural reference model.
  bit          m_en = 0;
  bit          m_start = 0;
  int          m_idx = 0;
  logic [7:0]  m_code = 0;
  logic [31:0] m_res = 0;
  int          m_cnt = 0;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int w;
    w = int'(a) / 4;
    if (w == int'(A_CTRL) / 4) return cmd(m_idx, m_code, m_start);
    if (w == int'(A_RES) / 4)  return m_res;
    if (w >= int'(A_WIN) / 4 && w < int'(A_WIN) / 4 + 64) return fw(w - int'(A_WIN) / 4);
    return 32'h0;
  endfunction

  function automatic string m_tag(input logic [11:0] a);
    int w;
    w = int'(a) / 4;
    if (w == int'(A_CTRL) / 4) return "R2 R3 R4 R6 R7 ctrl";
    if (w == int'(A_RES) / 4)  return "R5 result";
    if (w >= int'(A_WIN) / 4 && w < int'(A_WIN) / 4 + 64) return "R8 R10 window";
    return "R9 unmapped";
  endfunction

  always begin
    @(posedge clk);
    if (m_en) begin
      bit was_busy;
      was_busy = m_start;
      if (m_start) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_start = 0;
          m_res   = fw(m_idx);
        end
      end
      if (we && (addr[11:2] == A_CTRL[11:2]) && !was_busy) begin
        if (wdata[1] && wdata[15:8] == 8'hAC) begin
          m_idx = int'(wdata[24:16]); m_code = 8'hAC; m_start = 1; m_cnt = LAT + 1;
        end else if (!wdata[1]) begin
          m_idx = 0; m_code = 0; m_start = 0;
        end
      end
    end
    #5;
    if (m_en) check(m_tag(addr), rdata, m_read(addr));
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(posedge clk); #5; d = rdata;
  endtask

  // Runs one command read; returns the result word.
  task automatic cmd_read(input int i, output logic [31:0] res);
    int ones;
    logic [31:0] v;
    bus_write(A_CTRL, cmd(i, 8'hAC, 1));
    ones = 0;
    for (int k = 0; k < 4 * LAT; k++) begin
      @(posedge clk); #5;
      if (rdata[1]) ones++;
      else break;
    end
    check("R4 start width", ones, LAT);
    bus_read(A_RES, res);
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CTRL, v);
    check("R7 ctrl cleared", v, 32'h0);
    bus_read(A_RES, v);
    check("R5 result held after clear", v, res);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, r;
    rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_en = 1;

    bus_read(A_CTRL, v); check("R1 ctrl reset", v, 32'h0);
    bus_read(A_RES, v);  check("R1 result reset", v, 32'h0);

    // Accepted command reads back its fields.
    bus_write(A_CTRL, cmd(17, 8'hAC, 1));
    @(posedge clk); #5;
    check("R2 ctrl readback", rdata, cmd(17, 8'hAC, 1));
    repeat (LAT + 2) @(posedge clk);
    bus_read(A_RES, v); check("R5 result idx 17", v, fw(17));
    bus_write(A_CTRL, 32'h0);

    // Every index: window versus command path.
    for (int i = 0; i < 64; i++) begin
      bus_read(A_WIN + 12'(4 * i), v);
      check("R8 R10 window word", v, fw(i));
      cmd_read(i, r);
      check("R5 command word", r, fw(i));
      check("R8 window equals command", r, v);
    end

    // Indices beyond the array.
    cmd_read(100, r); check("R5 out of range 100", r, 32'h0);
    cmd_read(511, r); check("R5 out of range 511", r, 32'h0);
    cmd_read(63, r);  check("R5 last index", r, fw(63));

    // Bad unlock code.
    bus_write(A_CTRL, cmd(4, 8'h55, 1));
    bus_read(A_CTRL, v); check("R3 bad code ignored", v, 32'h0);
    repeat (LAT + 3) @(posedge clk);
    bus_read(A_RES, v); check("R3 result unchanged", v, fw(63));

    // Writes while busy.
    bus_write(A_CTRL, cmd(5, 8'hAC, 1));
    bus_write(A_CTRL, cmd(9, 8'hAC, 1));
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CTRL, v); check("R6 busy keeps fields", v, cmd(5, 8'hAC, 1));
    repeat (LAT + 2) @(posedge clk);
    bus_read(A_RES, v); check("R6 first command wins", v, fw(5));
    bus_read(A_CTRL, v); check("R6 index kept", v, cmd(5, 8'hAC, 0));
    bus_write(A_CTRL, 32'h0);

    // Unmapped reads and ineffective writes.
    bus_read(12'h000, v); check("R9 addr 000", v, 32'h0);
    bus_read(12'h044, v); check("R9 addr 044", v, 32'h0);
    bus_read(12'h300, v); check("R9 addr 300", v, 32'h0);
    bus_read(12'hFFC, v); check("R9 addr FFC", v, 32'h0);
    bus_write(A_RES, 32'hFFFF_FFFF);
    bus_read(A_RES, v); check("R9 result write ignored", v, fw(5));
    bus_write(A_WIN + 12'h00C, 32'h1234_5678);
    bus_read(A_WIN + 12'h00C, v); check("R9 window write ignored", v, fw(3));

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule